// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a very small processor. Every instruction is one byte and every data value is one byte, and both sit in a single 64-word memory inside the block. The core keeps three registers: a program counter, an instruction register and an accumulator. It also keeps a carry flag. Each instruction takes two clock cycles. In the first cycle the core reads the next instruction from memory. In the second cycle it carries that instruction out. There is no separate decode step.

A test environment uses the block as follows. It holds the `run` input low and writes a program and its data through the preload port. It then raises `run` and waits for the halted flag. Memory contents can be read back at any time through a combinational peek port. The accumulator, the carry flag, the program counter and the current phase are all visible as outputs.

Top module: `acc_machine`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0, `acc` is 0, `carry` is 0, `in_exec` is 0 (fetch phase) and `halted` is 0.
- R2: While `run` is high and the core is not halted, the phase alternates every clock: fetch (`in_exec`=0), then execute (`in_exec`=1). An instruction therefore takes exactly two cycles.
- R3: An instruction byte holds the opcode in bits [7:6] and a direct word address in bits [5:0]. The opcodes are 00 = LOAD, 01 = STORE, 10 = ADD and 11 = HALT.
- R4: A fetch copies memory[pc] into the instruction register and increments `pc` modulo 64, so that 63 wraps to 0.
- R5: LOAD sets `acc` to memory[address] and leaves `carry` unchanged.
- R6: STORE writes `acc` into memory[address] and leaves `acc` and `carry` unchanged.
- R7: ADD sets `acc` to (acc + memory[address]) mod 256 and sets `carry` to the bit carried out of bit 7.
- R8: HALT sets `halted`. From then until reset, `halted` stays set and `pc`, `acc`, `carry` and memory do not change.
- R9: While `run` is low, the core state (`pc`, `acc`, `carry`, phase) holds. `load_en` then writes `load_data` into memory[`load_addr`], and `peek_data` always shows memory[`peek_addr`] in the same cycle.
- R10: `acc` and `carry` change only on the clock edge that ends an execute phase, never during a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Lets the core advance when high |
| load_en | input | 1 | Preload write strobe (use while run is low) |
| load_addr | input | 6 | Preload word address |
| load_data | input | 8 | Preload write data |
| peek_addr | input | 6 | Read-back word address |
| peek_data | output | 8 | Memory word at peek_addr (combinational) |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry out of the most recent ADD |
| pc | output | 6 | Program counter |
| in_exec | output | 1 | High during the execute phase |
| halted | output | 1 | Set once HALT has executed |

## Verification
The checker tests several properties on every cycle:
- the strict alternation of fetch and execute, and the one-step advance of the program counter with wrap-around on each fetch;
- that the accumulator and carry stay unchanged across fetches;
- that all state holds while `run` is low;
- that the halted flag is sticky and freezes the registers.

Some behaviour depends on what memory actually holds, so only the directed scenarios can show it:
- the values produced by LOAD, ADD and STORE, including an ADD that overflows and a LOAD that must keep the carry;
- that STORE lands at the right word;
- the wrap from word 63 back to word 0.

// File: rtl/acc_pkg.sv
// Package: shared widths and encodings for the accumulator core.
// Assumes opcode and address together fill exactly one data word.
package acc_pkg;
    localparam int OP_W   = 2;
    localparam int ADDR_W = 6;
    localparam int DATA_W = OP_W + ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_HALT  = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e           op;
        logic [ADDR_W-1:0] addr;
    } instr_t;
endpackage

// File: rtl/acc_mem.sv
// Module: unified instruction/data memory, one write port and two
// combinational read ports (core and peek). The preload write takes
// priority over a core store; the two are not expected to coincide.
// No reset: memory contents survive a core reset.
module acc_mem
    import acc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] words [WORDS];

    // Write one word per cycle, preload first.
    always_ff @(posedge clk) begin
        if (pre_we)
            words[pre_addr] <= pre_data;
        else if (core_we)
            words[core_addr] <= core_wdata;
    end

    // Read both ports combinationally.
    assign core_rdata = words[core_addr];
    assign peek_data  = words[peek_addr];
endmodule

// File: rtl/acc_ctrl.sv
// Module: phase sequencer with program counter, instruction register
// and halt flag. Assumes the memory reads combinationally, so a fetch
// completes in one cycle.
module acc_ctrl
    import acc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output instr_t        ir,
    output logic [AW-1:0] pc,
    output logic          in_exec,
    output logic          halted,
    output logic          exec_fire
);
    logic active;

    assign active    = run && !halted;
    assign exec_fire = active && in_exec;

    // Fetch reads at pc; execute reads at the operand address.
    assign mem_addr = in_exec ? ir.addr : pc;

    // Advance the phase, pc and ir; latch halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            ir      <= '{op: OP_LOAD, addr: '0};
            in_exec <= 1'b0;
            halted  <= 1'b0;
        end else if (active) begin
            if (!in_exec) begin
                ir      <= instr_t'(mem_rdata);
                pc      <= pc + AW'(1);
                in_exec <= 1'b1;
            end else begin
                in_exec <= 1'b0;
                if (ir.op == OP_HALT)
                    halted <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/acc_datapath.sv
// Module: accumulator and carry with the execute-phase operations.
// Assumes exec_fire is high only in an execute cycle of a running core.
module acc_datapath
    import acc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_fire,
    input  opcode_e       op,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] acc,
    output logic          carry,
    output logic          store_we
);
    logic [DW:0] sum;

    assign sum      = {1'b0, acc} + {1'b0, operand};
    assign store_we = exec_fire && (op == OP_STORE);

    // Update the accumulator and carry on LOAD and ADD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            carry <= 1'b0;
        end else if (exec_fire) begin
            case (op)
                OP_LOAD: acc <= operand;
                OP_ADD:  {carry, acc} <= sum;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_machine.sv
// Module: top level of the two-phase accumulator core. Wires the
// sequencer, datapath and memory. Assumes the preload port is used
// only while run is low.
module acc_machine
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic [ADDR_W-1:0] pc,
    output logic              in_exec,
    output logic              halted
);
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    instr_t            ir;
    logic              exec_fire;
    logic              store_we;

    acc_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .ir        (ir),
        .pc        (pc),
        .in_exec   (in_exec),
        .halted    (halted),
        .exec_fire (exec_fire)
    );

    acc_datapath #(.DW(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_fire (exec_fire),
        .op        (ir.op),
        .operand   (mem_rdata),
        .acc       (acc),
        .carry     (carry),
        .store_we  (store_we)
    );

    acc_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk        (clk),
        .pre_we     (load_en),
        .pre_addr   (load_addr),
        .pre_data   (load_data),
        .core_we    (store_we),
        .core_addr  (mem_addr),
        .core_wdata (acc),
        .core_rdata (mem_rdata),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data)
    );
endmodule

// File: rtl/acc_machine_chk.sv
// Checker: cycle-level properties of the accumulator core, observed
// at its ports. Attached to every acc_machine by the bind below.
module acc_machine_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [DATA_W-1:0] acc,
    input logic              carry,
    input logic [ADDR_W-1:0] pc,
    input logic              in_exec,
    input logic              halted
);
    // R1: state seen right after a reset cycle
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && acc == '0 && !carry && !in_exec && !halted));

    // R2: phase toggles on every active cycle
    p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halted) |=> (in_exec != $past(in_exec)));

    // R4: a fetch advances pc by one, modulo 64
    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halted && !in_exec) |=> (pc == $past(pc) + ADDR_W'(1)));

    // R8: halt is sticky and freezes the registers
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc) && $stable(carry)));

    // R9: nothing moves while run is low
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(pc) && $stable(acc) && $stable(carry) && $stable(in_exec)));

    // R10: a fetch never touches the accumulator or the carry
    p_fetch_no_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exec |=> ($stable(acc) && $stable(carry)));
endmodule

bind acc_machine acc_machine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .acc     (acc),
    .carry   (carry),
    .pc      (pc),
    .in_exec (in_exec),
    .halted  (halted)
);

// File: tb/tb_acc_machine.sv
// Directed bench for acc_machine: one task per scenario.
module tb_acc_machine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       load_en = 1'b0;
    logic [5:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [5:0] peek_addr = '0;
    logic [7:0] peek_data;
    logic [7:0] acc;
    logic       carry;
    logic [5:0] pc;
    logic       in_exec;
    logic       halted;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    acc_machine dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .acc(acc), .carry(carry), .pc(pc), .in_exec(in_exec), .halted(halted)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic poke(input logic [5:0] a, input logic [7:0] d);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic peek_check(input string req, input logic [5:0] a,
                              input logic [7:0] exp);
        peek_addr = a;
        #1;
        check(req, "peek", peek_data, exp);
    endtask

    // Let the core run for n rising edges; always called at a negedge.
    task automatic step(input int n);
        run = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "pc", pc, 0);
        check("R1", "acc", acc, 0);
        check("R1", "carry", carry, 0);
        check("R1", "in_exec", in_exec, 0);
        check("R1", "halted", halted, 0);
    endtask

    task automatic t_program();
        do_reset();
        // R3: instruction byte = {op[1:0], addr[5:0]}
        poke(6'd0, 8'h14);   // LOAD 20
        poke(6'd1, 8'h95);   // ADD 21
        poke(6'd2, 8'h56);   // STORE 22
        poke(6'd3, 8'h97);   // ADD 23
        poke(6'd4, 8'h58);   // STORE 24
        poke(6'd5, 8'h19);   // LOAD 25
        poke(6'd6, 8'hC0);   // HALT
        poke(6'd20, 8'h70);
        poke(6'd21, 8'h25);
        poke(6'd22, 8'h00);
        poke(6'd23, 8'hF0);
        poke(6'd24, 8'h00);
        poke(6'd25, 8'h11);
        peek_check("R9", 6'd23, 8'hF0);
        check("R9", "pc held during preload", pc, 0);
        step(1);
        check("R2", "in_exec after fetch", in_exec, 1);
        check("R4", "pc after fetch", pc, 1);
        check("R10", "acc untouched by fetch", acc, 0);
        step(1);
        check("R5", "acc after LOAD", acc, 8'h70);
        check("R2", "back to fetch", in_exec, 0);
        step(2);
        check("R7", "acc after ADD", acc, 8'h95);
        check("R7", "carry clear", carry, 0);
        repeat (5) @(negedge clk);
        check("R9", "pc held while idle", pc, 2);
        check("R9", "acc held while idle", acc, 8'h95);
        step(2);
        peek_check("R6", 6'd22, 8'h95);
        check("R6", "acc kept by STORE", acc, 8'h95);
        step(2);
        check("R7", "acc after overflow ADD", acc, 8'h85);
        check("R7", "carry set", carry, 1);
        step(2);
        peek_check("R6", 6'd24, 8'h85);
        step(2);
        check("R5", "acc after LOAD", acc, 8'h11);
        check("R5", "carry kept by LOAD", carry, 1);
        check("R8", "not halted yet", halted, 0);
        step(2);
        check("R8", "halted", halted, 1);
        check("R8", "pc at halt", pc, 7);
        step(20);
        check("R8", "still halted", halted, 1);
        check("R8", "pc frozen", pc, 7);
        check("R8", "acc frozen", acc, 8'h11);
        check("R8", "carry frozen", carry, 1);
        peek_check("R8", 6'd24, 8'h85);
        do_reset();
        check("R1", "halt cleared by reset", halted, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        // Every word holds LOAD 63 (0x3F), so the core walks all 64 words.
        for (int i = 0; i < 64; i++) poke(6'(i), 8'h3F);
        step(128);
        check("R4", "pc wrapped", pc, 0);
        check("R5", "acc from word 63", acc, 8'h3F);
        check("R2", "phase after wrap", in_exec, 0);
        step(1);
        check("R4", "pc after wrap fetch", pc, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_program();
                t_wrap();
            end
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule